// File: doc/BRIEF.md
# Event Timer with Width Modes

This block is a register-mapped event timer. It holds a free-running 64-bit main counter that advances by one on each `tickEn` pulse while the run bit is set, and one comparator that raises a sticky fired flag when the counter reaches it. Software reaches every register through a 32-bit bus. Each 64-bit quantity is split into a low word and a high word, with the high word 4 bytes above the low word. A 64-bit counter read made of two word reads can tear when the low word rolls over between them.

The comparator runs either one-shot or periodic. In periodic mode each match adds the stored period to the comparator, so events recur without software help. A value-set bit lets software load the comparator directly in periodic mode. A narrow (32-bit) mode limits the match and the counter rollover to the low word, holds the counter's high word at zero, and makes the periodic addition wrap modulo 2^32. The counter then wraps every 2^32 ticks.

Register map (byte offsets; bit 0 is the LSB):
- `0x00` run control: bit 0 `run`.
- `0x04` status: bit 0 `fired`.
- `0x08` timer config: bit 0 `intEn`, bit 1 `periodic`, bit 2 `valueSet`, bit 3 `narrow`.
- `0x10` counter low, `0x14` counter high.
- `0x18` comparator low, `0x1C` comparator high.

Unmapped offsets read as zero.

Top module: `evtmr_top`

## Requirements
- R1: After reset, run control, status and timer config read 0, both counter words read 0, both comparator words read 0xFFFFFFFF, `irq` is low, and no match is armed.
- R2: While `run` (0x00 bit 0) is 1, each cycle with `tickEn` high adds 1 to the counter; while `run` is 0 the counter holds. Writes to 0x10/0x14 take effect only while `run` is 0 and are ignored while it is 1.
- R3: With `narrow` clear, a rollover of the counter's low word carries into the high word.
- R4: With `narrow` (0x08 bit 3) set, 0x14 reads 0, the stored high word is cleared, and the low word wraps from 0xFFFFFFFF to 0 with no carry.
- R5: With `narrow` set, a match compares only the low words; the comparator high word is kept and reads back, but it has no effect on the match.
- R6: A match occurs when the counter equals the comparator while `run` is 1. It sets `fired` (0x04 bit 0) one cycle later. `fired` stays set until software writes 1 to bit 0 of 0x04; writing 0 has no effect, and a match in the same cycle as the clear wins. `irq` is `fired` AND `intEn` (0x08 bit 0). In one-shot mode a comparator value fires at most once per comparator write.
- R7: In periodic mode (0x08 bit 1), each match adds the period to the comparator on the following clock edge.
- R8: In periodic mode with `valueSet` clear, a write to 0x18/0x1C updates only the matching half of the period and leaves the comparator unchanged.
- R9: With `valueSet` (0x08 bit 2) set in periodic mode, a write to 0x18/0x1C loads that half of both the comparator and the period. Any comparator write clears `valueSet`.
- R10: The periodic addition wraps modulo 2^64, or modulo 2^32 on the low word with the high word kept when `narrow` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Counter tick pulse |
| busAddr | input | ADDR_W | Register byte offset |
| busWrEn | input | 1 | Write strobe, captured at the clock edge |
| busWrData | input | HALF_W | Write data |
| busRdData | output | HALF_W | Read data, combinational from `busAddr` |
| irq | output | 1 | Level interrupt: `fired` AND `intEn` |

## Verification
A register write takes effect at the clock edge that captures it, and read data is valid within the same cycle, so the bench samples reads 1 ns after the falling edge. A tick changes the counter at the next edge. A match seen in the cycle after that sets `fired` and reloads a periodic comparator one edge later. Every status or comparator read after a tick therefore begins with a falling-edge wait, which lets that second edge pass before the sample. `irq` is sampled only once the config and status registers have settled. The sweeps walk the counter across each match point one tick at a time and compare against comparator and fire counts computed in the bench.

// File: rtl/evtmr_pkg.sv
package evtmr_pkg;

  localparam int OFS_RUNCTL = 'h00;
  localparam int OFS_STATUS = 'h04;
  localparam int OFS_TCFG   = 'h08;
  localparam int OFS_CNTLO  = 'h10;
  localparam int OFS_CNTHI  = 'h14;
  localparam int OFS_CMPLO  = 'h18;
  localparam int OFS_CMPHI  = 'h1C;

  // control -> datapath strobes
  typedef struct packed {
    logic run;
    logic narrow;
    logic periodic;
    logic countStep;
    logic cntWrLo;
    logic cntWrHi;
    logic cmpWrLo;
    logic cmpWrHi;
    logic perWrLo;
    logic perWrHi;
  } evtmr_strobe_t;

endpackage

// File: rtl/evtmr_datapath.sv
module evtmr_datapath
  import evtmr_pkg::*;
#(
  parameter int HALF_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  evtmr_strobe_t         strobe,
  input  logic [HALF_W-1:0]     wrData,
  output logic [2*HALF_W-1:0]   cntValue,
  output logic [2*HALF_W-1:0]   cmpValue,
  output logic                  matchHit
);

  localparam int FULL_W = 2 * HALF_W;

  logic [FULL_W-1:0] cntQ, cntNext;
  logic [FULL_W-1:0] cmpQ, cmpNext;
  logic [FULL_W-1:0] perQ, perNext;
  logic              armedQ, armedNext;
  logic              eqLo, eqHi, hit;
  logic [FULL_W-1:0] sumWide;
  logic [FULL_W-1:0] sumNarrow;

  // counter next value
  always_comb begin
    cntNext = cntQ;
    if (strobe.countStep) begin
      if (strobe.narrow)
        cntNext = {{HALF_W{1'b0}}, cntQ[HALF_W-1:0] + HALF_W'(1)};
      else
        cntNext = cntQ + FULL_W'(1);
    end
    if (strobe.cntWrLo) cntNext[HALF_W-1:0] = wrData;
    if (strobe.cntWrHi) cntNext[FULL_W-1:HALF_W] = wrData;
    if (strobe.narrow)  cntNext[FULL_W-1:HALF_W] = '0;
  end

  // match detection
  always_comb begin
    eqLo     = cntQ[HALF_W-1:0] == cmpQ[HALF_W-1:0];
    eqHi     = cntQ[FULL_W-1:HALF_W] == cmpQ[FULL_W-1:HALF_W];
    hit      = eqLo && (strobe.narrow || eqHi);
    matchHit = strobe.run && armedQ && hit;
  end

  // periodic reload sums
  always_comb begin
    sumWide   = cmpQ + perQ;
    sumNarrow = {cmpQ[FULL_W-1:HALF_W], cmpQ[HALF_W-1:0] + perQ[HALF_W-1:0]};
  end

  // comparator, period and arming
  always_comb begin
    cmpNext   = cmpQ;
    perNext   = perQ;
    armedNext = armedQ;
    if (matchHit) begin
      if (strobe.periodic)
        cmpNext = strobe.narrow ? sumNarrow : sumWide;
      else
        armedNext = 1'b0;
    end
    if (strobe.cmpWrLo) cmpNext[HALF_W-1:0] = wrData;
    if (strobe.cmpWrHi) cmpNext[FULL_W-1:HALF_W] = wrData;
    if (strobe.cmpWrLo || strobe.cmpWrHi) armedNext = 1'b1;
    if (strobe.perWrLo) perNext[HALF_W-1:0] = wrData;
    if (strobe.perWrHi) perNext[FULL_W-1:HALF_W] = wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ   <= '0;
      cmpQ   <= '1;
      perQ   <= '0;
      armedQ <= 1'b0;
    end else begin
      cntQ   <= cntNext;
      cmpQ   <= cmpNext;
      perQ   <= perNext;
      armedQ <= armedNext;
    end
  end

  assign cntValue = cntQ;
  assign cmpValue = cmpQ;

endmodule

// File: rtl/evtmr_ctrl.sv
module evtmr_ctrl
  import evtmr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int HALF_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  tickEn,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic                  busWrEn,
  input  logic [HALF_W-1:0]     busWrData,
  input  logic                  matchHit,
  input  logic [2*HALF_W-1:0]   cntValue,
  input  logic [2*HALF_W-1:0]   cmpValue,
  output evtmr_strobe_t         strobe,
  output logic [HALF_W-1:0]     busRdData,
  output logic                  irq
);

  localparam int FULL_W = 2 * HALF_W;

  logic runQ, intEnQ, periodicQ, valueSetQ, narrowQ, firedQ;
  logic selRun, selStatus, selCfg, selCntLo, selCntHi, selCmpLo, selCmpHi;
  logic directCmp, cmpTouched;

  always_comb begin
    selRun    = busWrEn && (busAddr == ADDR_W'(OFS_RUNCTL));
    selStatus = busWrEn && (busAddr == ADDR_W'(OFS_STATUS));
    selCfg    = busWrEn && (busAddr == ADDR_W'(OFS_TCFG));
    selCntLo  = busWrEn && (busAddr == ADDR_W'(OFS_CNTLO));
    selCntHi  = busWrEn && (busAddr == ADDR_W'(OFS_CNTHI));
    selCmpLo  = busWrEn && (busAddr == ADDR_W'(OFS_CMPLO));
    selCmpHi  = busWrEn && (busAddr == ADDR_W'(OFS_CMPHI));
    directCmp  = !periodicQ || valueSetQ;
    cmpTouched = selCmpLo || selCmpHi;
  end

  always_comb begin
    strobe.run       = runQ;
    strobe.narrow    = narrowQ;
    strobe.periodic  = periodicQ;
    strobe.countStep = runQ && tickEn;
    strobe.cntWrLo   = selCntLo && !runQ;
    strobe.cntWrHi   = selCntHi && !runQ;
    strobe.cmpWrLo   = selCmpLo && directCmp;
    strobe.cmpWrHi   = selCmpHi && directCmp;
    strobe.perWrLo   = selCmpLo && periodicQ;
    strobe.perWrHi   = selCmpHi && periodicQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ      <= 1'b0;
      intEnQ    <= 1'b0;
      periodicQ <= 1'b0;
      valueSetQ <= 1'b0;
      narrowQ   <= 1'b0;
      firedQ    <= 1'b0;
    end else begin
      if (selRun) runQ <= busWrData[0];
      if (selCfg) begin
        intEnQ    <= busWrData[0];
        periodicQ <= busWrData[1];
        valueSetQ <= busWrData[2];
        narrowQ   <= busWrData[3];
      end else if (cmpTouched) begin
        valueSetQ <= 1'b0;
      end
      if (matchHit)
        firedQ <= 1'b1;
      else if (selStatus && busWrData[0])
        firedQ <= 1'b0;
    end
  end

  always_comb begin
    busRdData = '0;
    case (busAddr)
      ADDR_W'(OFS_RUNCTL): busRdData = {{(HALF_W-1){1'b0}}, runQ};
      ADDR_W'(OFS_STATUS): busRdData = {{(HALF_W-1){1'b0}}, firedQ};
      ADDR_W'(OFS_TCFG):   busRdData = {{(HALF_W-4){1'b0}}, narrowQ, valueSetQ, periodicQ, intEnQ};
      ADDR_W'(OFS_CNTLO):  busRdData = cntValue[HALF_W-1:0];
      ADDR_W'(OFS_CNTHI):  busRdData = narrowQ ? '0 : cntValue[FULL_W-1:HALF_W];
      ADDR_W'(OFS_CMPLO):  busRdData = cmpValue[HALF_W-1:0];
      ADDR_W'(OFS_CMPHI):  busRdData = cmpValue[FULL_W-1:HALF_W];
      default:             busRdData = '0;
    endcase
  end

  assign irq = firedQ && intEnQ;

endmodule

// File: rtl/evtmr_top.sv
module evtmr_top
  import evtmr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int HALF_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [HALF_W-1:0] busWrData,
  output logic [HALF_W-1:0] busRdData,
  output logic              irq
);

  evtmr_strobe_t         strobeBus;
  logic [2*HALF_W-1:0]   cntValue;
  logic [2*HALF_W-1:0]   cmpValue;
  logic                  matchHit;

  evtmr_ctrl #(.ADDR_W(ADDR_W), .HALF_W(HALF_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .tickEn    (tickEn),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .matchHit  (matchHit),
    .cntValue  (cntValue),
    .cmpValue  (cmpValue),
    .strobe    (strobeBus),
    .busRdData (busRdData),
    .irq       (irq)
  );

  evtmr_datapath #(.HALF_W(HALF_W)) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobeBus),
    .wrData   (busWrData),
    .cntValue (cntValue),
    .cmpValue (cmpValue),
    .matchHit (matchHit)
  );

endmodule

// File: rtl/evtmr_checker.sv
module evtmr_checker
  import evtmr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int HALF_W = 32
) (
  input logic                clk,
  input logic                rstN,
  input evtmr_strobe_t       strobe,
  input logic [2*HALF_W-1:0] cntValue,
  input logic                matchHit,
  input logic [ADDR_W-1:0]   busAddr,
  input logic                busWrEn,
  input logic [HALF_W-1:0]   busWrData,
  input logic                fired,
  input logic                valueSet,
  input logic                irq
);

  localparam int FULL_W = 2 * HALF_W;

  logic clearReq;
  assign clearReq = busWrEn && (busAddr == ADDR_W'(OFS_STATUS)) && busWrData[0];

  assert_narrow_upper_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.narrow && $past(strobe.narrow) |-> cntValue[FULL_W-1:HALF_W] == '0);

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.countStep && !strobe.narrow |=> cntValue == $past(cntValue) + FULL_W'(1));

  assert_halt_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.run && !strobe.cntWrLo && !strobe.cntWrHi && !strobe.narrow |=> $stable(cntValue));

  assert_valueset_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    valueSet && (strobe.cmpWrLo || strobe.cmpWrHi) |=> !valueSet);

  assert_match_sets_fired_R6: assert property (@(posedge clk) disable iff (!rstN)
    matchHit |=> fired);

  assert_fired_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    fired && !clearReq |=> fired);

  assert_oneshot_once_R6: assert property (@(posedge clk) disable iff (!rstN)
    matchHit && !strobe.periodic && !strobe.cmpWrLo && !strobe.cmpWrHi |=> !matchHit);

  assert_irq_needs_fired_R6: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> fired);

endmodule

bind evtmr_top evtmr_checker #(.ADDR_W(ADDR_W), .HALF_W(HALF_W)) u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .strobe    (strobeBus),
  .cntValue  (cntValue),
  .matchHit  (matchHit),
  .busAddr   (busAddr),
  .busWrEn   (busWrEn),
  .busWrData (busWrData),
  .fired     (u_ctrl.firedQ),
  .valueSet  (u_ctrl.valueSetQ),
  .irq       (irq)
);

// File: tb/evtmr_top_bench.sv
`timescale 1ns/1ps
module evtmr_top_bench;

  localparam logic [7:0] A_RUN = 8'h00, A_STAT = 8'h04, A_CFG = 8'h08;
  localparam logic [7:0] A_CNTLO = 8'h10, A_CNTHI = 8'h14, A_CMPLO = 8'h18, A_CMPHI = 8'h1C;

  logic        clk = 0;
  logic        rstN = 0;
  logic        tickEn = 0;
  logic [7:0]  busAddr = 0;
  logic        busWrEn = 0;
  logic [31:0] busWrData = 0;
  logic [31:0] busRdData;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  evtmr_top u_evtmr_top (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(busRdData), .irq(irq)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1;
    @(negedge clk);
    busWrEn = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1;
    d = busRdData;
  endtask

  task automatic tick();
    @(negedge clk);
    tickEn = 1;
    @(negedge clk);
    tickEn = 0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  logic [31:0] v;
  logic [31:0] expCmp;
  int fires;

  initial begin
    idle(3);
    rstN = 1;
    // R1 reset state
    rd(A_RUN, v);   check("R1 run", v, 0);
    rd(A_STAT, v);  check("R1 status", v, 0);
    rd(A_CFG, v);   check("R1 cfg", v, 0);
    rd(A_CNTLO, v); check("R1 cntlo", v, 0);
    rd(A_CNTHI, v); check("R1 cnthi", v, 0);
    rd(A_CMPLO, v); check("R1 cmplo", v, 32'hFFFFFFFF);
    rd(A_CMPHI, v); check("R1 cmphi", v, 32'hFFFFFFFF);
    check("R1 irq", irq, 0);

    // R2 counting sweep
    wr(A_CNTLO, 5);
    rd(A_CNTLO, v); check("R2 halted write", v, 5);
    wr(A_RUN, 1);
    begin
      int total = 5;
      for (int n = 0; n < 8; n++) begin
        for (int t = 0; t < n; t++) tick();
        idle(n % 3);
        total += n;
        rd(A_CNTLO, v); check($sformatf("R2 sweep n=%0d", n), v, total);
      end
      wr(A_CNTLO, 32'h99);
      rd(A_CNTLO, v); check("R2 write ignored while running", v, total);
      wr(A_RUN, 0);
      tick(); tick(); tick();
      rd(A_CNTLO, v); check("R2 halted ticks ignored", v, total);
    end

    // R3 carry into high word
    wr(A_CNTLO, 32'hFFFFFFFE); wr(A_CNTHI, 3);
    wr(A_RUN, 1);
    tick(); tick(); tick();
    rd(A_CNTLO, v); check("R3 low after carry", v, 1);
    rd(A_CNTHI, v); check("R3 high after carry", v, 4);

    // R4 narrow counter
    wr(A_RUN, 0);
    wr(A_CNTHI, 7); wr(A_CNTLO, 32'hFFFFFFFF);
    rd(A_CNTHI, v); check("R4 high before narrow", v, 7);
    wr(A_CFG, 32'h8);
    rd(A_CNTHI, v); check("R4 high reads zero", v, 0);
    wr(A_RUN, 1);
    tick();
    rd(A_CNTLO, v); check("R4 low wraps", v, 0);
    rd(A_CNTHI, v); check("R4 no carry", v, 0);
    wr(A_RUN, 0); wr(A_CFG, 0);
    rd(A_CNTHI, v); check("R4 stored high cleared", v, 0);

    // R5 narrow match ignores comparator high
    wr(A_CFG, 32'h9);
    wr(A_CNTLO, 8);
    wr(A_CMPHI, 32'h55); wr(A_CMPLO, 10);
    wr(A_STAT, 1);
    wr(A_RUN, 1);
    tick();
    rd(A_STAT, v); check("R5 no early fire", v, 0);
    tick();
    rd(A_STAT, v); check("R5 low-word match fires", v, 1);
    check("R5 irq", irq, 1);
    rd(A_CMPHI, v); check("R5 high word kept", v, 32'h55);

    // R6 one-shot sweep
    wr(A_RUN, 0); wr(A_CFG, 0);
    wr(A_CNTLO, 0); wr(A_CNTHI, 0);
    wr(A_CMPHI, 0); wr(A_CMPLO, 4);
    wr(A_STAT, 1);
    rd(A_STAT, v); check("R6 cleared", v, 0);
    wr(A_RUN, 1);
    for (int i = 1; i <= 6; i++) begin
      tick();
      rd(A_STAT, v); check($sformatf("R6 fired at count %0d", i), v, (i == 4));
      if (i == 4) begin
        check("R6 irq masked", irq, 0);
        wr(A_CFG, 1);
        check("R6 irq enabled", irq, 1);
        wr(A_STAT, 0);
        rd(A_STAT, v); check("R6 write 0 keeps", v, 1);
        wr(A_STAT, 1);
        idle(3);
        rd(A_STAT, v); check("R6 no refire while equal", v, 0);
        check("R6 irq low after clear", irq, 0);
        wr(A_CFG, 0);
      end
    end

    // R7 / R9 periodic sweep
    wr(A_RUN, 0); wr(A_CFG, 0);
    wr(A_CNTLO, 0); wr(A_CNTHI, 0);
    wr(A_CFG, 32'h6);
    wr(A_CMPLO, 3);
    rd(A_CFG, v); check("R9 valueSet self-clears lo", v, 32'h2);
    wr(A_CFG, 32'h6);
    wr(A_CMPHI, 0);
    rd(A_CFG, v); check("R9 valueSet self-clears hi", v, 32'h2);
    rd(A_CMPLO, v); check("R9 comparator loaded", v, 3);
    wr(A_STAT, 1);
    wr(A_RUN, 1);
    expCmp = 3; fires = 0;
    for (int i = 1; i <= 12; i++) begin
      tick();
      if (i == expCmp) begin expCmp += 3; fires++; end
      rd(A_CMPLO, v); check($sformatf("R7 comparator at count %0d", i), v, expCmp);
      rd(A_STAT, v);
      if (v[0]) begin
        fires--;
        wr(A_STAT, 1);
      end
    end
    check("R7 each match fired once", fires, 0);

    // R8 period-only write
    wr(A_RUN, 0);
    wr(A_CFG, 32'h2);
    wr(A_CMPLO, 5);
    rd(A_CMPLO, v); check("R8 comparator unchanged", v, 15);
    wr(A_RUN, 1);
    tick(); tick(); tick();
    rd(A_CMPLO, v); check("R8 new period used", v, 20);

    // R10 narrow periodic wrap
    wr(A_RUN, 0);
    wr(A_CFG, 32'hA);
    wr(A_CNTLO, 32'hFFFFFFF0);
    wr(A_CFG, 32'hE);
    wr(A_CMPLO, 32'hFFFFFFF8);
    wr(A_CMPLO, 32'h10);
    rd(A_CMPLO, v); check("R10 narrow cmp loaded", v, 32'hFFFFFFF8);
    wr(A_STAT, 1);
    wr(A_RUN, 1);
    for (int t = 0; t < 8; t++) tick();
    rd(A_CMPLO, v); check("R10 narrow wrap low", v, 32'h8);
    rd(A_CMPHI, v); check("R10 narrow high kept", v, 0);
    rd(A_STAT, v);  check("R10 narrow fired", v, 1);

    // R10 wide periodic wrap
    wr(A_RUN, 0);
    wr(A_CFG, 32'h6); wr(A_CMPLO, 32'hFFFFFFFF);
    wr(A_CFG, 32'h6); wr(A_CMPHI, 32'hFFFFFFFF);
    wr(A_CMPLO, 2); wr(A_CMPHI, 0);
    wr(A_CNTLO, 32'hFFFFFFFE); wr(A_CNTHI, 32'hFFFFFFFF);
    wr(A_RUN, 1);
    tick();
    rd(A_CMPLO, v); check("R10 wide wrap low", v, 1);
    rd(A_CMPHI, v); check("R10 wide wrap high", v, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule